// File: doc/BRIEF.md
# Radio Interrupt Source Router

This block gathers single-cycle event pulses from a packet radio's transmit and receive paths and holds each one in a sticky status word. Each status bit can then reach any combination of three interrupt lines, chosen by one enable mask per line. A host reads the status word to find out which event fired. It clears the events it has handled by writing a mask of ones, and it programs the three line masks through the same small register port.

Six sources are defined. Bit 0 is transmit finished. Bit 1 is receive finished. Bit 2 is preamble seen. Bit 3 is sync word matched. Bit 4 is header accepted. Bit 5 is header checksum failure. The packet type input decides which receive sources may latch. Sync word matched is only accepted in GFSK mode. The two header sources are only accepted in LoRa mode. The first three sources are accepted in either mode. An event only latches when its source is enabled on at least one line.

Register map on the two-bit address: 0 reads the status word, and a write to it is a clear mask. Addresses 1, 2 and 3 hold the masks for lines 0, 1 and 2.

Top module: `radio_irq_router`

## Requirements
- R1: After reset the status word, all three line masks and all three interrupt lines are zero.
- R2: A latched status bit reads back as 1 at address 0 and stays set for as long as no clear is written for it.
- R3: An event pulse whose source bit is zero in all three line masks leaves the status word unchanged.
- R4: Bit 3 latches only while `pkt_lora` is 0. Bits 4 and 5 latch only while `pkt_lora` is 1. Bits 0 to 2 latch in either mode.
- R5: A write to address 0 clears each status bit whose `wr_data` bit is 1 and leaves the other bits unchanged.
- R6: When an event for a bit and a clear of that same bit fall in the same cycle, the bit ends up set.
- R7: `irq_line[l]` is 1 exactly when the status word and the mask of line l shared a set bit in the previous cycle. One source may drive several lines at once.
- R8: Bits 15 to 6 of the status word and of every mask always read as 0, and writes to them have no effect.
- R9: A write to address 1, 2 or 3 stores bits 5 to 0 as the mask of line 0, 1 or 2, and a read of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_lora | input | 1 | Packet type: 1 = LoRa, 0 = GFSK |
| evt | input | 6 | Event pulses, one bit per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| irq_line | output | 3 | Interrupt lines, registered, active high |

## Verification
A wrong latch or clear in the status register shows up at address 0 on the cycle right after the event or the write. It also reaches the interrupt lines one cycle after that, so every stimulus is checked first at the register port and then at the lines. A mode gate or enable gate that leaks becomes a stray status bit that stays readable indefinitely. A lost event in a clear collision becomes a missing bit that cannot recover.

// File: rtl/radio_irq_router.sv
module radio_irq_router #(
  parameter int DATA_W  = 16,
  parameter int NUM_SRC = 6,
  parameter int NUM_IRQ = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_lora,
  input  logic [NUM_SRC-1:0] evt,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_IRQ-1:0] irq_line
);
  localparam logic [DATA_W-1:0] IMPL = DATA_W'((1 << NUM_SRC) - 1);

  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] mask_q [NUM_IRQ];
  logic [DATA_W-1:0] evt_w, allowed, en_any, set_v, clr_v;

  assign evt_w   = DATA_W'(evt);
  assign allowed = DATA_W'({pkt_lora, pkt_lora, ~pkt_lora, 3'b111});

  always_comb begin
    en_any = '0;
    for (int l = 0; l < NUM_IRQ; l++) en_any = en_any | mask_q[l];
  end

  assign set_v = evt_w & allowed & en_any & IMPL;
  assign clr_v = (wr_en && wr_addr == 2'd0) ? (wr_data & IMPL) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_v) | set_v;
  end

  for (genvar l = 0; l < NUM_IRQ; l++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[l]   <= '0;
        irq_line[l] <= 1'b0;
      end else begin
        if (wr_en && wr_addr == 2'(l + 1)) mask_q[l] <= wr_data & IMPL;
        irq_line[l] <= |(status_q & mask_q[l]);
      end
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = status_q;
      2'd1:    rd_data = mask_q[0];
      2'd2:    rd_data = mask_q[1];
      default: rd_data = mask_q[2];
    endcase
  end

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 2'd0) |=> (($past(status_q) & ~status_q) == '0)); // R2
  AST_NO_MASKED_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~($past(mask_q[0]) | $past(mask_q[1]) | $past(mask_q[2]))) == '0)); // R3
  AST_SYNC_GFSK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[3]) |-> $past(!pkt_lora)); // R4
  AST_HDR_LORA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status_q[4]) || $rose(status_q[5])) |-> $past(pkt_lora)); // R4
  AST_LINES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |=> (irq_line == '0)); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~IMPL) == '0); // R8
endmodule

// File: tb/radio_irq_router_bench.sv
module radio_irq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_lora = 1'b1;
  logic [5:0]  evt = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [2:0]  irq_line;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  radio_irq_router u_radio_irq_router (.*);

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(logic [5:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    for (int a = 0; a < 4; a++) begin rd(2'(a), d); chk("R1 reg", d, 16'h0); end
    chk("R1 irq", 16'(irq_line), 16'h0);
  endtask

  task automatic t_masked;
    logic [15:0] d;
    pulse(6'h3F); rd(0, d); chk("R3 no enable", d, 16'h0);
  endtask

  task automatic t_masks;
    logic [15:0] d;
    wr(1, 16'hFFC7); wr(2, 16'h0008); wr(3, 16'h0030);
    rd(1, d); chk("R9 mask0 R8 upper", d, 16'h0007);
    rd(2, d); chk("R9 mask1", d, 16'h0008);
    rd(3, d); chk("R9 mask2", d, 16'h0030);
  endtask

  task automatic t_gating;
    logic [15:0] d;
    pkt_lora = 1; pulse(6'h01); rd(0, d); chk("R2 tx done", d, 16'h0001);
    @(negedge clk); chk("R7 line0", 16'(irq_line), 16'h1);
    pulse(6'h08); rd(0, d); chk("R4 sync in lora", d, 16'h0001);
    pkt_lora = 0; pulse(6'h08); rd(0, d); chk("R4 sync in gfsk", d, 16'h0009);
    pulse(6'h30); rd(0, d); chk("R4 hdr in gfsk", d, 16'h0009);
    pkt_lora = 1; pulse(6'h30); rd(0, d); chk("R4 hdr in lora", d, 16'h0039);
    @(negedge clk); chk("R7 all lines", 16'(irq_line), 16'h7);
    repeat (5) @(negedge clk);
    rd(0, d); chk("R2 sticky", d, 16'h0039);
  endtask

  task automatic t_clear;
    logic [15:0] d;
    wr(0, 16'hFFC1); rd(0, d); chk("R5 R8 clear bit0", d, 16'h0038);
    @(negedge clk); chk("R7 line0 drops", 16'(irq_line), 16'h6);
    @(negedge clk); wr_en = 1; wr_addr = 0; wr_data = 16'h0001; evt = 6'h01;
    @(negedge clk); wr_en = 0; evt = '0;
    rd(0, d); chk("R6 event beats clear", d, 16'h0039);
    wr(0, 16'h0038); rd(0, d); chk("R5 partial clear", d, 16'h0001);
    @(negedge clk); chk("R7 only line0", 16'(irq_line), 16'h1);
  endtask

  task automatic t_multi;
    logic [15:0] d;
    wr(1, 16'h0020); pulse(6'h20);
    @(negedge clk); chk("R7 one source two lines", 16'(irq_line), 16'h5);
    wr(0, 16'h003F); rd(0, d); chk("R5 clear all", d, 16'h0);
    @(negedge clk); chk("R7 lines low", 16'(irq_line), 16'h0);
  endtask

  initial begin
    #1000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog got=%h exp=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_masked;
    t_masks;
    t_gating;
    t_clear;
    t_multi;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule